// File: doc/BRIEF.md
# Dual-Mode PWM Channel with Boundary-Loaded Compare

This block is one pulse-width-modulated output driven by a free-running counter. Two values set it up: a period and a duty. Both are written through simple strobe-and-data ports into holding (shadow) registers. They are copied into the working registers only when the counter reaches the end of its cycle, so a new setting never cuts a pulse short or stretches one partway through a cycle.

The counter runs in one of two ways. In edge-aligned operation it climbs from zero to the period value and starts again at zero. In centre-aligned operation it climbs to the period value and then falls back to zero, so the pulse sits symmetrically about the turning point. For the same resolution, this gives half the carrier frequency. A duty of zero keeps the pin low for the whole cycle, and a duty above the period keeps it high for the whole cycle. A one-cycle event pulse marks every point where new values are loaded, so software can supply the next duty from an interrupt.

Top module: `pwm_dual_mode`

## Requirements
- R1: While reset is asserted and just after it is released, `pwm_out` and `period_evt` are 0, the counter is 0 and the working period and duty are 0.
- R2: With `mode_centre`=0 and `en`=1, the counter steps 0,1,...,P and then wraps to 0, so a cycle lasts P+1 clocks and holds exactly one event.
- R3: With `mode_centre`=1 and `en`=1, the counter steps 0,1,...,P,P-1,...,1 and then returns to 0, so a cycle lasts 2P clocks for P>=1 and holds exactly one event. With P=0 the counter stays at 0 and an event occurs on every clock.
- R4: `pwm_out` is 1 exactly in the cycles where the counter value is below the working duty D. In edge-aligned operation this gives min(D, P+1) high clocks per cycle.
- R5: In centre-aligned operation with 1<=D<=P, `pwm_out` is high for 2D-1 of the 2P clocks of a cycle.
- R6: D=0 gives no high clock in a cycle, in either mode. D>P gives a high output on every clock of the cycle.
- R7: A write to `per_wdata` or `duty_wdata` affects only the shadow registers. The working values change only at a cycle boundary (the edge where the counter goes to 0). A write on the same edge as a boundary is loaded at the following boundary.
- R8: `period_evt` is high for the single clock that follows each boundary load. In that clock the counter reads 0.
- R9: While `en`=0, the counter, its direction and the working values hold, `pwm_out` keeps its level and `period_evt` is 0. Writes to the shadow registers are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Counter clock enable |
| mode_centre | input | 1 | 0 = edge-aligned (count up and wrap), 1 = centre-aligned (count up then down) |
| per_wr | input | 1 | Period shadow write strobe |
| per_wdata | input | CNT_W | Period value to write |
| duty_wr | input | 1 | Duty shadow write strobe |
| duty_wdata | input | CNT_W+1 | Duty value to write; one bit wider than the period so 100% is reachable |
| pwm_out | output | 1 | Modulated output |
| period_evt | output | 1 | One-clock pulse after each boundary load |

## Verification
On every clock, the assertions check the invariants that can be seen in a single cycle. The counter never exceeds the working period. The output level always agrees with the counter against the working duty. The working values move only on a boundary edge. An event always coincides with a zero count. A disabled clock freezes the count and suppresses events. Other properties cover whole cycles or need a history of writes, and only the bench scenarios can show them. These are the exact number of high clocks per cycle in each mode (the 2D-1 centre-aligned count and the 0% and 100% extremes), the cycle lengths of P+1 and 2P, and a duty write taking effect only at the next boundary, or at the one after that when it lands on the boundary edge.

// File: rtl/pwm_dm_pkg.sv
package pwm_dm_pkg;
  typedef enum logic {
    CNT_UP   = 1'b0,
    CNT_DOWN = 1'b1
  } cnt_dir_e;
endpackage

// File: rtl/pwm_dm_rst_sync.sv
module pwm_dm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/pwm_dm_regs.sv
module pwm_dm_regs #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              per_wr,
  input  logic [CNT_W-1:0]  per_wdata,
  input  logic              duty_wr,
  input  logic [DUTY_W-1:0] duty_wdata,
  input  logic              load,
  output logic [CNT_W-1:0]  per_act,
  output logic [DUTY_W-1:0] duty_act,
  output logic [DUTY_W-1:0] duty_nxt
);
  logic [CNT_W-1:0]  per_sh_q,   per_sh_d;
  logic [DUTY_W-1:0] duty_sh_q,  duty_sh_d;
  logic [CNT_W-1:0]  per_act_q,  per_act_d;
  logic [DUTY_W-1:0] duty_act_q, duty_act_d;

  // shadow capture and boundary transfer; the transfer sees the pre-edge shadow
  always_comb begin
    per_sh_d   = per_sh_q;
    duty_sh_d  = duty_sh_q;
    per_act_d  = per_act_q;
    duty_act_d = duty_act_q;
    if (per_wr)  per_sh_d  = per_wdata;
    if (duty_wr) duty_sh_d = duty_wdata;
    if (load) begin
      per_act_d  = per_sh_q;
      duty_act_d = duty_sh_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q   <= '0;
      duty_sh_q  <= '0;
      per_act_q  <= '0;
      duty_act_q <= '0;
    end else begin
      per_sh_q   <= per_sh_d;
      duty_sh_q  <= duty_sh_d;
      per_act_q  <= per_act_d;
      duty_act_q <= duty_act_d;
    end
  end

  assign per_act  = per_act_q;
  assign duty_act = duty_act_q;
  assign duty_nxt = duty_act_d;
endmodule

// File: rtl/pwm_dm_counter.sv
module pwm_dm_counter
  import pwm_dm_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             centre,
  input  logic [CNT_W-1:0] per_act,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             term
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  cnt_dir_e         dir_q, dir_d;
  logic             at_top;

  assign at_top = (cnt_q >= per_act);

  always_comb begin
    cnt_d = cnt_q;
    dir_d = dir_q;
    term  = 1'b0;
    if (en) begin
      if (!centre) begin
        // edge-aligned: count up, wrap after the period value
        term  = (cnt_q == per_act);
        cnt_d = term ? ZERO : cnt_q + ONE;
        dir_d = CNT_UP;
      end else begin
        // centre-aligned: up to the period, back down to zero
        if (dir_q == CNT_UP) begin
          if (at_top) cnt_d = (per_act == ZERO) ? ZERO : cnt_q - ONE;
          else        cnt_d = cnt_q + ONE;
        end else begin
          cnt_d = cnt_q - ONE;
        end
        term = (cnt_d == ZERO);
        if (term)                           dir_d = CNT_UP;
        else if (dir_q == CNT_UP && at_top) dir_d = CNT_DOWN;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= CNT_UP;
    end else if (en) begin
      cnt_q <= cnt_d;
      dir_q <= dir_d;
    end
  end

  assign cnt     = cnt_q;
  assign cnt_nxt = cnt_d;
endmodule

// File: rtl/pwm_dm_out.sv
module pwm_dm_out #(
  parameter int CNT_W  = 8,
  parameter int DUTY_W = CNT_W + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              term,
  input  logic [CNT_W-1:0]  cnt_nxt,
  input  logic [DUTY_W-1:0] duty_nxt,
  output logic              pwm,
  output logic              evt
);
  localparam int PAD_W = DUTY_W - CNT_W;

  logic pwm_d, pwm_q, evt_q;

  // registered compare of the values that will hold after this edge
  assign pwm_d = ({{PAD_W{1'b0}}, cnt_nxt} < duty_nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwm_q <= 1'b0;
      evt_q <= 1'b0;
    end else begin
      pwm_q <= pwm_d;
      evt_q <= term;
    end
  end

  assign pwm = pwm_q;
  assign evt = evt_q;
endmodule

// File: rtl/pwm_dual_mode.sv
module pwm_dual_mode #(
  parameter int CNT_W      = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             mode_centre,
  input  logic             per_wr,
  input  logic [CNT_W-1:0] per_wdata,
  input  logic             duty_wr,
  input  logic [CNT_W:0]   duty_wdata,
  output logic             pwm_out,
  output logic             period_evt
);
  localparam int DUTY_W = CNT_W + 1;

  logic              rst_sync_n;
  logic              term;
  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  cnt_nxt;
  logic [CNT_W-1:0]  per_act;
  logic [DUTY_W-1:0] duty_act;
  logic [DUTY_W-1:0] duty_nxt;

  pwm_dm_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  pwm_dm_regs #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .per_wr     (per_wr),
    .per_wdata  (per_wdata),
    .duty_wr    (duty_wr),
    .duty_wdata (duty_wdata),
    .load       (term),
    .per_act    (per_act),
    .duty_act   (duty_act),
    .duty_nxt   (duty_nxt)
  );

  pwm_dm_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .en      (en),
    .centre  (mode_centre),
    .per_act (per_act),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt),
    .term    (term)
  );

  pwm_dm_out #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .term     (term),
    .cnt_nxt  (cnt_nxt),
    .duty_nxt (duty_nxt),
    .pwm      (pwm_out),
    .evt      (period_evt)
  );
endmodule

// File: rtl/pwm_dual_mode_chk.sv
module pwm_dual_mode_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             term,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] per_act,
  input logic [CNT_W:0]   duty_act,
  input logic             pwm,
  input logic             evt
);
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= per_act);

  assert_wrap_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> (cnt == '0));

  assert_pwm_level_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pwm == ({1'b0, cnt} < duty_act));

  assert_active_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !term |=> ($stable(duty_act) && $stable(per_act)));

  assert_evt_at_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |-> (cnt == '0));

  assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(cnt) && !evt && $stable(pwm)));
endmodule

bind pwm_dual_mode pwm_dual_mode_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en),
  .term     (term),
  .cnt      (cnt),
  .per_act  (per_act),
  .duty_act (duty_act),
  .pwm      (pwm_out),
  .evt      (period_evt)
);

// File: tb/pwm_dual_mode_tb.sv
`timescale 1ns/1ps
module pwm_dual_mode_tb;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic en, mode_centre, per_wr, duty_wr;
  logic [CNT_W-1:0] per_wdata;
  logic [CNT_W:0]   duty_wdata;
  logic pwm_out, period_evt;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench model state
  int m_cnt, m_per, m_duty, m_psh, m_dsh;
  bit m_down, m_pwm, m_evt;

  always #10 clk = ~clk;

  pwm_dual_mode #(.CNT_W(CNT_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .mode_centre(mode_centre),
    .per_wr(per_wr), .per_wdata(per_wdata), .duty_wr(duty_wr),
    .duty_wdata(duty_wdata), .pwm_out(pwm_out), .period_evt(period_evt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // expected sequence: edge 0..P wrap; centre 0..P..1 back to 0
  task automatic model_edge();
    int nxt;
    bit bnd, ndown;
    nxt = m_cnt; ndown = m_down; bnd = 1'b0;
    if (en) begin
      if (!mode_centre) begin
        bnd = (m_cnt == m_per);
        nxt = bnd ? 0 : m_cnt + 1;
        ndown = 1'b0;
      end else begin
        if (m_down)               nxt = m_cnt - 1;
        else if (m_cnt >= m_per)  nxt = (m_per == 0) ? 0 : m_per - 1;
        else                      nxt = m_cnt + 1;
        bnd = (nxt == 0);
        ndown = bnd ? 1'b0 : (m_down || m_cnt >= m_per);
      end
    end
    if (bnd) begin
      m_per = m_psh;
      m_duty = m_dsh;
    end
    if (per_wr)  m_psh = int'(per_wdata);
    if (duty_wr) m_dsh = int'(duty_wdata);
    m_cnt = nxt; m_down = ndown;
    m_pwm = (m_cnt < m_duty);
    m_evt = bnd;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    per_wr = 1'b0;
    duty_wr = 1'b0;
    chk("R4 model pwm", int'(pwm_out), int'(m_pwm));
    chk("R8 model evt", int'(period_evt), int'(m_evt));
  endtask

  task automatic wait_evt();
    int guard = 0;
    while (!period_evt && guard < 2000) begin
      step();
      guard++;
    end
  endtask

  task automatic configure(input int per, input int duty, input bit centre);
    mode_centre = centre;
    per_wr = 1'b1; per_wdata = CNT_W'(per);
    duty_wr = 1'b1; duty_wdata = (CNT_W+1)'(duty);
    step();
    step();
    wait_evt();
  endtask

  task automatic measure(input int n, output int hi, output int ev);
    hi = 0; ev = 0;
    for (int i = 0; i < n; i++) begin
      hi += int'(pwm_out);
      ev += int'(period_evt);
      step();
    end
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int hi, ev, p0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; en = 1'b0; mode_centre = 1'b0;
    per_wr = 1'b0; duty_wr = 1'b0; per_wdata = '0; duty_wdata = '0;
    m_cnt = 0; m_per = 0; m_duty = 0; m_psh = 0; m_dsh = 0;
    m_down = 1'b0; m_pwm = 1'b0; m_evt = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset pwm", int'(pwm_out), 0);
    chk("R1 reset evt", int'(period_evt), 0);
    rst_n = 1'b1;
    repeat (4) step();
    chk("R1 idle pwm after release", int'(pwm_out), 0);
    en = 1'b1;

    // edge-aligned
    configure(9, 3, 1'b0);
    measure(10, hi, ev);
    chk("R4 edge P9 D3 highs", hi, 3);
    chk("R2 edge P9 events per cycle", ev, 1);
    configure(9, 0, 1'b0);
    measure(10, hi, ev);
    chk("R6 edge duty 0 highs", hi, 0);
    configure(9, 20, 1'b0);
    measure(10, hi, ev);
    chk("R6 edge duty>P highs", hi, 10);

    // shadow: write during a cycle is deferred to the next boundary
    configure(9, 3, 1'b0);
    duty_wr = 1'b1; duty_wdata = 9'd8;
    measure(10, hi, ev);
    chk("R7 duty held in current cycle", hi, 3);
    measure(10, hi, ev);
    chk("R7 duty loaded at boundary", hi, 8);

    // centre-aligned
    configure(6, 4, 1'b1);
    measure(12, hi, ev);
    chk("R5 centre P6 D4 highs", hi, 7);
    chk("R3 centre P6 events per cycle", ev, 1);
    configure(6, 9, 1'b1);
    measure(12, hi, ev);
    chk("R6 centre duty>P highs", hi, 12);
    configure(6, 0, 1'b1);
    measure(12, hi, ev);
    chk("R6 centre duty 0 highs", hi, 0);
    configure(0, 1, 1'b1);
    measure(5, hi, ev);
    chk("R3 centre P0 event every clock", ev, 5);
    chk("R4 centre P0 D1 highs", hi, 5);

    // enable low freezes
    configure(7, 4, 1'b0);
    step(); step();
    p0 = int'(pwm_out);
    en = 1'b0;
    for (int i = 0; i < 6; i++) begin
      step();
      chk("R9 pwm held while disabled", int'(pwm_out), p0);
      chk("R9 no event while disabled", int'(period_evt), 0);
    end
    en = 1'b1;

    // random mix against the bench model (R7 same-edge writes included)
    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(7) == 0) begin
        per_wr = 1'b1; per_wdata = CNT_W'($urandom_range(12));
      end
      if ($urandom_range(5) == 0) begin
        duty_wr = 1'b1; duty_wdata = (CNT_W+1)'($urandom_range(15));
      end
      if ($urandom_range(59) == 0) mode_centre = ~mode_centre;
      if ($urandom_range(29) == 0) en = ~en;
      step();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule